// File: doc/BRIEF.md
# Time-Compare Periodic Pin Generator

This block drives a periodic square wave on an output pin, for example a one-pulse-per-second marker, from a free-running fixed-point system time value supplied by a separate counter. Software loads a 64-bit start time and a 64-bit half-period, both in raw counter units, as pairs of 32-bit words. It then writes an auxiliary control word that arms the generator. Whenever the system time is at or beyond the pending compare value, the wave level flips and the compare value moves forward by exactly one half-period. The phase therefore stays locked to the programmed start time and does not drift by the amount the counter overshoots on each step.

The pin is driven only when it is configured as an output and routed to the timing function. Each flip of the level can latch an interrupt cause, which reaches the interrupt line only while a mask bit is set. Software rounds the start time to a whole second of counter time before writing it. The time counter itself is outside this block.

Top module: `pps_clock_out`

## Requirements
- R1: After reset, pin_out, pin_oe, irq and irq_cause are all 0.
- R2: With auxiliary bits enable (bit 0) and sync (bit 1) written as 1 at address 4, the first level flip happens at the first clock edge at which sys_time is greater than or equal to the programmed start time, and not before.
- R3: After each flip the next compare value is the previous compare value plus the half-period, so the number of flips equals the number of points start + k*half-period that sys_time has reached, whatever the counter step.
- R4: The compare is greater-or-equal with at most one flip per clock; when sys_time jumps past several compare points, one flip occurs on each following edge until the compare value passes sys_time.
- R5: With enable set and sync (bit 1) clear, the first compare value is sys_time at the arming write plus the half-period.
- R6: Any write to the auxiliary word (address 4) drops the level to 0 and discards the pending compare; writing 0 leaves the output low with no further flips.
- R7: A time_reset pulse drops the level to 0 and disarms the generator until the auxiliary word is written again.
- R8: Pin word at address 5: bit 0 sets pin_oe; bit 1 routes the wave to the pin; otherwise pin_out follows bit 2. pin_out is 0 while bit 0 is 0.
- R9: Each level flip sets irq_cause when the auxiliary interrupt bit (bit 2) is set; with bit 2 clear, flips leave irq_cause unchanged. Writing 1 in bit 0 at address 8 clears it.
- R10: irq is irq_cause gated by a mask bit; writing 1 in bit 0 at address 6 sets the mask, at address 7 clears it.
- R11: Start time and half-period are written as 32-bit words: start low at address 0, high at 1; half-period low at 2, high at 3. A compare involving the high word behaves as a full 64-bit compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_time | input | 64 | Running system time in raw counter units |
| time_reset | input | 1 | Pulse marking a reset of the time counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Output pin value |
| pin_oe | output | 1 | Output pin drive enable |
| irq | output | 1 | Masked interrupt request |
| irq_cause | output | 1 | Latched pin-change cause |

## Verification
The hardest situation to reach is a system time that has already passed several compare points when the generator looks at it, which forces a run of back-to-back flips. The bench arms the generator while time is held at zero, then makes sys_time jump far beyond the start time in one step and holds it there, so the catch-up flips appear one per cycle. A slow counter step that does not divide the half-period exercises the no-drift rule, and a start time straddling the 32-bit word boundary exercises the full-width compare.

// File: rtl/pps_pkg.sv
package pps_pkg;
   // register word addresses; the lane layout of the 64-bit words matters
   localparam int unsigned ADR_TGT_BASE = 0;
   localparam int unsigned ADR_PER_BASE = 2;
   localparam int unsigned ADR_AUX      = 4;
   localparam int unsigned ADR_PIN      = 5;
   localparam int unsigned ADR_MSET     = 6;
   localparam int unsigned ADR_MCLR     = 7;
   localparam int unsigned ADR_CCLR     = 8;

   // auxiliary control bits
   localparam int unsigned AUX_EN   = 0;
   localparam int unsigned AUX_SYNC = 1;
   localparam int unsigned AUX_INT  = 2;

   // pin control bits
   localparam int unsigned PIN_DIR = 0;
   localparam int unsigned PIN_NAT = 1;
   localparam int unsigned PIN_GPO = 2;

   typedef struct packed {
      logic en;
      logic sync;
      logic intr;
   } aux_t;

   typedef struct packed {
      logic dir;
      logic nat;
      logic gpo;
   } pin_t;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
   import pps_pkg::*;
#(
   parameter int unsigned TIME_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [TIME_W-1:0] target,
   output logic [TIME_W-1:0] period,
   output logic              aux_wr,
   output aux_t              aux_new,
   output aux_t              aux_q,
   output pin_t              pin_q,
   output logic              mask_set,
   output logic              mask_clr,
   output logic              cause_clr
);
   localparam int unsigned NWORDS = TIME_W / WORD_W;

   generate
      if (TIME_W != NWORDS * WORD_W || NWORDS != 2) begin : g_bad_width
         $error("pps_regs: TIME_W must be exactly two register words");
      end
      if ((1 << ADDR_W) <= ADR_CCLR) begin : g_bad_addr
         $error("pps_regs: ADDR_W too narrow for the register map");
      end
   endgenerate

   function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned want);
      return a == ADDR_W'(want);
   endfunction

   logic [WORD_W-1:0] tgt_w [NWORDS];
   logic [WORD_W-1:0] per_w [NWORDS];

   generate
      for (genvar i = 0; i < NWORDS; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tgt_w[i] <= '0;
               per_w[i] <= '0;
            end else if (wr_en) begin
               if (hit_addr(wr_addr, ADR_TGT_BASE + i)) tgt_w[i] <= wr_data;
               if (hit_addr(wr_addr, ADR_PER_BASE + i)) per_w[i] <= wr_data;
            end
         end
         assign target[i*WORD_W +: WORD_W] = tgt_w[i];
         assign period[i*WORD_W +: WORD_W] = per_w[i];
      end
   endgenerate

   assign aux_wr       = wr_en && hit_addr(wr_addr, ADR_AUX);
   assign aux_new.en   = wr_data[AUX_EN];
   assign aux_new.sync = wr_data[AUX_SYNC];
   assign aux_new.intr = wr_data[AUX_INT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q <= '0;
         pin_q <= '0;
      end else if (wr_en) begin
         if (aux_wr) aux_q <= aux_new;
         if (hit_addr(wr_addr, ADR_PIN)) begin
            pin_q.dir <= wr_data[PIN_DIR];
            pin_q.nat <= wr_data[PIN_NAT];
            pin_q.gpo <= wr_data[PIN_GPO];
         end
      end
   end

   assign mask_set  = wr_en && hit_addr(wr_addr, ADR_MSET) && wr_data[0];
   assign mask_clr  = wr_en && hit_addr(wr_addr, ADR_MCLR) && wr_data[0];
   assign cause_clr = wr_en && hit_addr(wr_addr, ADR_CCLR) && wr_data[0];
endmodule

// File: rtl/pps_edge_gen.sv
module pps_edge_gen
   import pps_pkg::*;
#(
   parameter int unsigned TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              time_reset,
   input  logic [TIME_W-1:0] target,
   input  logic [TIME_W-1:0] period,
   input  logic              aux_wr,
   input  aux_t              aux_new,
   output logic              level,
   output logic              flip
);
   logic              armed_q;
   logic              level_q;
   logic [TIME_W-1:0] cmp_q;
   logic              reached;

   assign reached = sys_time >= cmp_q;
   assign flip    = armed_q && reached && !time_reset && !aux_wr;
   assign level   = level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         level_q <= 1'b0;
         cmp_q   <= '0;
      end else if (time_reset) begin
         armed_q <= 1'b0;
         level_q <= 1'b0;
      end else if (aux_wr) begin
         level_q <= 1'b0;
         armed_q <= aux_new.en;
         cmp_q   <= aux_new.sync ? target : sys_time + period;
      end else if (flip) begin
         level_q <= ~level_q;
         cmp_q   <= cmp_q + period;
      end
   end

   assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      time_reset |=> (!level_q && !armed_q));

   assert_aux_write_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_wr && !time_reset) |=> !level_q);

   assert_rise_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level_q) |-> ($past(armed_q) && ($past(sys_time) >= $past(cmp_q))));

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !aux_wr) |=> !level_q || $stable(level_q));
endmodule

// File: rtl/pps_irq.sv
module pps_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   input  logic int_en,
   input  logic mask_set,
   input  logic mask_clr,
   input  logic cause_clr,
   output logic cause,
   output logic irq
);
   logic cause_q;
   logic mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         if (flip && int_en) cause_q <= 1'b1;
         else if (cause_clr) cause_q <= 1'b0;
         if (mask_set)      mask_q <= 1'b1;
         else if (mask_clr) mask_q <= 1'b0;
      end
   end

   assign cause = cause_q;
   assign irq   = cause_q & mask_q;

   assert_flip_sets_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flip && int_en) |=> cause_q);

   assert_mask_clear_quiets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_clr && !mask_set) |=> !irq);
endmodule

// File: rtl/pps_clock_out.sv
module pps_clock_out
   import pps_pkg::*;
#(
   parameter int unsigned TIME_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              time_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              irq,
   output logic              irq_cause
);
   logic [TIME_W-1:0] target;
   logic [TIME_W-1:0] period;
   logic              aux_wr;
   aux_t              aux_new;
   aux_t              aux_q;
   pin_t              pin_q;
   logic              mask_set;
   logic              mask_clr;
   logic              cause_clr;
   logic              level;
   logic              flip;

   pps_regs #(.TIME_W(TIME_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .target(target), .period(period), .aux_wr(aux_wr), .aux_new(aux_new),
      .aux_q(aux_q), .pin_q(pin_q), .mask_set(mask_set), .mask_clr(mask_clr),
      .cause_clr(cause_clr)
   );

   pps_edge_gen #(.TIME_W(TIME_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .time_reset(time_reset),
      .target(target), .period(period), .aux_wr(aux_wr), .aux_new(aux_new),
      .level(level), .flip(flip)
   );

   pps_irq u_irq (
      .clk(clk), .rst_n(rst_n), .flip(flip), .int_en(aux_q.intr),
      .mask_set(mask_set), .mask_clr(mask_clr), .cause_clr(cause_clr),
      .cause(irq_cause), .irq(irq)
   );

   assign pin_oe  = pin_q.dir;
   assign pin_out = pin_q.dir && (pin_q.nat ? level : pin_q.gpo);

   assert_pin_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_out);
endmodule

// File: tb/sim_pps_clock_out.sv
module sim_pps_clock_out;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] sys_time = '0;
   logic        time_reset = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pin_out, pin_oe, irq, irq_cause;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   logic [63:0] st_step = '0;

   // bench expectations
   logic [63:0] m_tgt = '0, m_per = '0, m_cmp = '0;
   logic        m_lvl = 0, m_arm = 0, m_int = 0, m_cause = 0, m_mask = 0;
   logic        m_dir = 0, m_nat = 0, m_gpo = 0;
   int          flips_seen = 0;
   logic        prev_pin = 0;

   always #2.5 clk = ~clk;

   pps_clock_out u0 (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .time_reset(time_reset),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_cause(irq_cause)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
         end
      end
   end

   // one clock: expectation from pre-edge inputs, then checks after the edge
   task automatic tick(input string req);
      logic exp_pin;
      if (time_reset) begin
         m_lvl = 0; m_arm = 0;
      end else if (wr_en && wr_addr == 4) begin
         m_lvl = 0; m_arm = wr_data[0];
         m_cmp = wr_data[1] ? m_tgt : sys_time + m_per;
      end else if (m_arm && sys_time >= m_cmp) begin
         m_lvl = ~m_lvl; m_cmp = m_cmp + m_per;
         if (m_int) m_cause = 1;
         else if (wr_en && wr_addr == 8 && wr_data[0]) m_cause = 0;
      end else if (wr_en && wr_addr == 8 && wr_data[0]) m_cause = 0;
      if (wr_en) begin
         case (wr_addr)
            0: m_tgt[31:0]  = wr_data;
            1: m_tgt[63:32] = wr_data;
            2: m_per[31:0]  = wr_data;
            3: m_per[63:32] = wr_data;
            4: m_int = wr_data[2];
            5: begin m_dir = wr_data[0]; m_nat = wr_data[1]; m_gpo = wr_data[2]; end
            6: if (wr_data[0]) m_mask = 1;
            7: if (wr_data[0]) m_mask = 0;
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      exp_pin = m_dir && (m_nat ? m_lvl : m_gpo);
      chk({req, " pin_out"}, 64'(pin_out), 64'(exp_pin));
      chk({req, " pin_oe"}, 64'(pin_oe), 64'(m_dir));
      chk({req, " irq_cause"}, 64'(irq_cause), 64'(m_cause));
      chk({req, " irq"}, 64'(irq), 64'(m_cause & m_mask));
      if (pin_out != prev_pin) flips_seen++;
      prev_pin = pin_out;
      sys_time = sys_time + st_step;
   endtask

   task automatic wr(input string req, input logic [3:0] a, input logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick(req);
      wr_en = 0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 pin_out", 64'(pin_out), 0);
      chk("R1 pin_oe", 64'(pin_oe), 0);
      chk("R1 irq", 64'(irq), 0);
      chk("R1 irq_cause", 64'(irq_cause), 0);
      rst_n = 1;

      // R8/R11 configuration: pin routed, mask on, half-period 10, start 25
      wr("R8", 5, 32'h3);
      wr("R10", 6, 32'h1);
      wr("R11", 2, 32'd10);
      wr("R11", 3, 32'd0);
      wr("R11", 0, 32'd25);
      wr("R11", 1, 32'd0);

      // R2: unit step, sync start at 25
      sys_time = 0; st_step = 1;
      wr("R2", 4, 32'h7);
      for (int i = 0; i < 60; i++) tick("R2");

      // R3: step 3 does not divide 10; count flips against the formula
      wr("R6", 4, 32'h0);
      sys_time = 0; st_step = 3;
      flips_seen = 0; prev_pin = pin_out;
      wr("R3", 4, 32'h3);
      for (int i = 0; i < 200; i++) tick("R3");
      // last pre-edge time sampled was sys_time - 3
      chk("R3 flip count", 64'(flips_seen), ((sys_time - 3 - 25) / 10) + 1);

      // R9: no interrupt bit -> cause stays; then clear and enable
      wr("R9", 8, 32'h1);
      wr("R9", 4, 32'h3);
      for (int i = 0; i < 30; i++) tick("R9");
      wr("R9", 4, 32'h7);
      for (int i = 0; i < 40; i++) tick("R9");
      wr("R9", 8, 32'h1);
      tick("R9");

      // R10: mask cleared hides cause
      wr("R10", 7, 32'h1);
      for (int i = 0; i < 20; i++) tick("R10");
      wr("R10", 6, 32'h1);
      tick("R10");

      // R4: arm at time 0, then jump to 55 and hold
      st_step = 0; sys_time = 0;
      wr("R4", 4, 32'h7);
      sys_time = 55;
      tick("R4");
      chk("R4 first catch-up flip", 64'(pin_out), 1);
      for (int i = 0; i < 6; i++) tick("R4");
      chk("R4 settled after four flips", 64'(pin_out), 0);

      // R5: free start, first compare = arm time + 10
      sys_time = 100; st_step = 1;
      wr("R5", 4, 32'h5);
      for (int i = 0; i < 40; i++) tick("R5");

      // R6: clear aux, output low, no flips
      wr("R6", 4, 32'h0);
      for (int i = 0; i < 30; i++) tick("R6");

      // R7: time_reset disarms
      sys_time = 0;
      wr("R7", 4, 32'h7);
      for (int i = 0; i < 28; i++) tick("R7");
      time_reset = 1;
      tick("R7");
      time_reset = 0;
      for (int i = 0; i < 40; i++) tick("R7");
      chk("R7 stays low", 64'(pin_out), 0);

      // R11: start time straddling the word boundary
      wr("R11", 1, 32'h1);
      wr("R11", 0, 32'h4);
      sys_time = 64'hFFFF_FFF0;
      wr("R11", 4, 32'h3);
      for (int i = 0; i < 50; i++) tick("R11");

      // R8: plain output value and undriven pin
      wr("R8", 5, 32'h5);
      tick("R8");
      wr("R8", 5, 32'h4);
      tick("R8");
      chk("R8 undriven low", 64'(pin_out), 0);

      summary();
   end
endmodule